// File: doc/BRIEF.md
# Power Stage Reset Sequencer

This block sits next to a PWM modulator and drives the active-low reset line of an external half-bridge power stage. While that reset is low, the stage is treated as high-impedance with every switch off. The block releases reset only after three things are true. First, the gate-drive supply has been reported good long enough for the bootstrap capacitors to precharge. Second, the modulator reports that it is initialised. Third, the PWM stream has been measured as switching inside its legal frequency band for a run of consecutive periods.

The block also enables the high-voltage bridge supply, and never before the gate supply is good. It forwards the PWM stream to the stage, and holds the forwarded PWM low during precharge so that the pulldowns can charge the bootstrap capacitors. When the block shuts down, mutes or loses its supplies, reset always falls before the forwarded PWM is withdrawn. If the PWM input stops toggling at either level, or its period leaves the band, reset is forced low at once. Default parameters assume a 100 MHz system clock: the band of 250 to 285 clocks per period corresponds to 350 to 400 kHz, and the precharge hold is 1.2 ms.

Top module: `pss_reset_seq`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, stage_rst_no, bridge_en_o and pwm_o are all 0.
- R2: bridge_en_o rises only on the clock edge after gate_ok_i is seen high with pwr_down_i low. Once it has dropped, it stays low while pwr_down_i is high.
- R3: After bridge_en_o rises, stage_rst_no stays low for at least PRECHARGE_CYC+1 cycles, and pwm_o is held at 0 for the first PRECHARGE_CYC cycles. If the other release conditions are already met, reset rises exactly PRECHARGE_CYC+1 cycles after bridge_en_o.
- R4: The PWM period is the number of system clocks between rising edges of pwm_i, measured after a two-flop synchroniser. It is legal when it lies in PER_MIN..PER_MAX inclusive. Reset is released only after VALID_RUNS consecutive legal periods.
- R5: A single period shorter than PER_MIN or longer than PER_MAX drives stage_rst_no low. Release then needs a fresh run of VALID_RUNS legal periods.
- R6: When STALL_CYC clocks pass with no synchronised rising edge (pwm_i stuck high or stuck low), stage_rst_no is low on the next clock edge. Measured from the first clock edge after the last rise of pwm_i, reset is still high STALL_CYC+2 edges later and low STALL_CYC+3 edges later.
- R7: mute_i high, or mod_ready_i low, drives stage_rst_no low on the next edge while PWM forwarding continues. Reset rises again on the edge after the request clears, provided the PWM stream is still legal.
- R8: pwr_down_i high, or gate_ok_i low, after power-up drives stage_rst_no low on the next edge. pwm_o keeps forwarding pwm_i for DRAIN_CYC more cycles, and then bridge_en_o and forwarding drop together. Forwarding never stops while reset is high.
- R9: pwm_o equals pwm_i while forwarding and is 0 otherwise. Forwarding is on whenever stage_rst_no is high.
- R10: After a shutdown, a new start needs gate_ok_i high and pwr_down_i low, and repeats the full precharge hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the sequencer |
| gate_ok_i | input | 1 | Gate-drive supply good (synchronous level) |
| pwr_down_i | input | 1 | Request to power the stage down |
| mod_ready_i | input | 1 | Modulator initialised and streaming |
| mute_i | input | 1 | Mute request; the stage goes high-impedance |
| pwm_i | input | 1 | PWM stream from the modulator (asynchronous) |
| pwm_o | output | 1 | PWM forwarded to the power stage |
| bridge_en_o | output | 1 | Enable for the high-voltage bridge supply |
| stage_rst_no | output | 1 | Active-low reset to the power stage |

## Verification
On every cycle the assertions check the ordering rules. The bridge supply may rise only after gate-good. Reset may rise only after the precharge count, with a valid stream, a ready modulator and no mute. Reset falls on the cycle after a stall, a mute or a power-down. Forwarding never drops while reset is high. Only the bench scenarios can show the exact period band edges, the consecutive-run count, the stall latency from the last PWM rise, the drain length, and the recovery paths after stuck levels and supply loss. To do so, the bench sweeps the PWM period across both band edges and replays the power events in several orders.

// File: rtl/pss_pkg.sv
`timescale 1ns/1ps
package pss_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_PRECHG = 3'd1,
    ST_ARM    = 3'd2,
    ST_RUN    = 3'd3,
    ST_DRAIN  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/pss_pwm_monitor.sv
`timescale 1ns/1ps
module pss_pwm_monitor #(
  parameter int PER_MIN    = 250,
  parameter int PER_MAX    = 285,
  parameter int STALL_CYC  = 520,
  parameter int VALID_RUNS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  output logic pwm_good_o,
  output logic stall_o
);
  localparam int CW = $clog2(STALL_CYC + 1);
  localparam int RW = $clog2(VALID_RUNS + 1);

  logic [1:0]    sync_q;
  logic          last_q;
  logic [CW-1:0] per_q;
  logic [RW-1:0] run_q;
  logic          rise, in_band;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pwm_i};
      last_q <= sync_q[1];
    end
  end

  assign rise    = sync_q[1] & ~last_q;
  assign stall_o = per_q >= CW'(STALL_CYC);
  assign in_band = (per_q >= CW'(PER_MIN)) && (per_q <= CW'(PER_MAX));

  // period counter saturates at the stall limit; starts saturated so the first edge is never legal
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       per_q <= CW'(STALL_CYC);
    else if (rise)     per_q <= CW'(1);
    else if (!stall_o) per_q <= per_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (rise) begin
      if (!in_band)                      run_q <= '0;
      else if (run_q != RW'(VALID_RUNS)) run_q <= run_q + RW'(1);
    end else if (stall_o) run_q <= '0;
  end

  assign pwm_good_o = (run_q == RW'(VALID_RUNS)) && !stall_o;
endmodule

// File: rtl/pss_precharge_timer.sv
`timescale 1ns/1ps
module pss_precharge_timer #(
  parameter int PRECHARGE_CYC = 120000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int PW = $clog2(PRECHARGE_CYC + 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + PW'(1);
  end

  assign done_o = run_i && (cnt_q == PW'(PRECHARGE_CYC - 1));
endmodule

// File: rtl/pss_seq_fsm.sv
`timescale 1ns/1ps
module pss_seq_fsm
  import pss_pkg::*;
#(
  parameter int DRAIN_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_ok_i,
  input  logic pwr_down_i,
  input  logic mod_ready_i,
  input  logic mute_i,
  input  logic pwm_good_i,
  input  logic prechg_done_i,
  output logic prechg_run_o,
  output logic stage_rst_no,
  output logic bridge_en_o,
  output logic pwm_pass_o
);
  localparam int DW = $clog2(DRAIN_CYC + 1);

  seq_state_e    state_q, state_d;
  logic [DW-1:0] drain_q;
  logic          drain_end, supply_fail, hold_low;

  assign supply_fail = !gate_ok_i || pwr_down_i;
  assign hold_low    = !mod_ready_i || mute_i || !pwm_good_i;
  assign drain_end   = (state_q == ST_DRAIN) && (drain_q == DW'(DRAIN_CYC - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:    if (gate_ok_i && !pwr_down_i) state_d = ST_PRECHG;
      ST_PRECHG: if (supply_fail)   state_d = ST_DRAIN;
                 else if (prechg_done_i) state_d = ST_ARM;
      ST_ARM:    if (supply_fail)   state_d = ST_DRAIN;
                 else if (!hold_low) state_d = ST_RUN;
      ST_RUN:    if (supply_fail)   state_d = ST_DRAIN;
                 else if (hold_low) state_d = ST_ARM;
      ST_DRAIN:  if (drain_end)     state_d = ST_OFF;
      default:                      state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_OFF;
      drain_q      <= '0;
      stage_rst_no <= 1'b0;
      bridge_en_o  <= 1'b0;
      pwm_pass_o   <= 1'b0;
    end else begin
      state_q      <= state_d;
      drain_q      <= (state_q == ST_DRAIN) ? drain_q + DW'(1) : '0;
      stage_rst_no <= (state_d == ST_RUN);
      bridge_en_o  <= (state_d != ST_OFF);
      // keep forwarding through drain only if it was already on
      pwm_pass_o   <= (state_d == ST_ARM) || (state_d == ST_RUN) ||
                      ((state_d == ST_DRAIN) && pwm_pass_o);
    end
  end

  assign prechg_run_o = (state_q == ST_PRECHG);
endmodule

// File: rtl/pss_reset_seq.sv
`timescale 1ns/1ps
module pss_reset_seq #(
  parameter int PRECHARGE_CYC = 120000,
  parameter int PER_MIN       = 250,
  parameter int PER_MAX       = 285,
  parameter int STALL_CYC     = 520,
  parameter int VALID_RUNS    = 16,
  parameter int DRAIN_CYC     = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_ok_i,
  input  logic pwr_down_i,
  input  logic mod_ready_i,
  input  logic mute_i,
  input  logic pwm_i,
  output logic pwm_o,
  output logic bridge_en_o,
  output logic stage_rst_no
);
  logic pwm_good, stall, pwm_pass, prechg_run, prechg_done;

  pss_pwm_monitor #(
    .PER_MIN   (PER_MIN),
    .PER_MAX   (PER_MAX),
    .STALL_CYC (STALL_CYC),
    .VALID_RUNS(VALID_RUNS)
  ) u_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwm_i     (pwm_i),
    .pwm_good_o(pwm_good),
    .stall_o   (stall)
  );

  pss_precharge_timer #(
    .PRECHARGE_CYC(PRECHARGE_CYC)
  ) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (prechg_run),
    .done_o(prechg_done)
  );

  pss_seq_fsm #(
    .DRAIN_CYC(DRAIN_CYC)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .gate_ok_i    (gate_ok_i),
    .pwr_down_i   (pwr_down_i),
    .mod_ready_i  (mod_ready_i),
    .mute_i       (mute_i),
    .pwm_good_i   (pwm_good),
    .prechg_done_i(prechg_done),
    .prechg_run_o (prechg_run),
    .stage_rst_no (stage_rst_no),
    .bridge_en_o  (bridge_en_o),
    .pwm_pass_o   (pwm_pass)
  );

  assign pwm_o = pwm_i & pwm_pass;
endmodule

// File: rtl/pss_reset_seq_chk.sv
`timescale 1ns/1ps
module pss_reset_seq_chk #(
  parameter int PRECHARGE_CYC = 120000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic gate_ok_i,
  input logic pwr_down_i,
  input logic mod_ready_i,
  input logic mute_i,
  input logic bridge_en_o,
  input logic stage_rst_no,
  input logic pwm_good,
  input logic stall,
  input logic pwm_pass
);
  localparam int BW = $clog2(PRECHARGE_CYC + 3);

  logic [BW-1:0] bc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          bc_q <= '0;
    else if (!bridge_en_o)                bc_q <= '0;
    else if (bc_q != BW'(PRECHARGE_CYC + 2)) bc_q <= bc_q + BW'(1);
  end

  // R2
  bridge_after_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bridge_en_o) |-> $past(gate_ok_i && !pwr_down_i));

  // R3
  precharge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stage_rst_no) |-> (bc_q > BW'(PRECHARGE_CYC)));

  // R4
  release_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stage_rst_no) |-> $past(pwm_good && mod_ready_i && !mute_i && gate_ok_i));

  // R6
  stall_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> !stage_rst_no);

  // R7
  mute_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_i || !mod_ready_i) |=> !stage_rst_no);

  // R8
  down_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_down_i || !gate_ok_i) |=> !stage_rst_no);

  // R8
  pwm_after_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwm_pass) |-> $past(!stage_rst_no));

  // R9
  fwd_while_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_rst_no |-> (pwm_pass && bridge_en_o));
endmodule

bind pss_reset_seq pss_reset_seq_chk #(
  .PRECHARGE_CYC(PRECHARGE_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gate_ok_i   (gate_ok_i),
  .pwr_down_i  (pwr_down_i),
  .mod_ready_i (mod_ready_i),
  .mute_i      (mute_i),
  .bridge_en_o (bridge_en_o),
  .stage_rst_no(stage_rst_no),
  .pwm_good    (pwm_good),
  .stall       (stall),
  .pwm_pass    (pwm_pass)
);

// File: tb/tb_pss_reset_seq.sv
`timescale 1ns/1ps
module tb_pss_reset_seq;
  localparam int P     = 100;
  localparam int PMIN  = 8;
  localparam int PMAX  = 12;
  localparam int STALL = 20;
  localparam int RUNS  = 4;
  localparam int DRAIN = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic gate_ok = 1'b0, pwr_down = 1'b0, mod_ready = 1'b0, mute = 1'b0, pwm_i = 1'b0;
  logic pwm_o, bridge_en, stage_rst_n;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  int per = 10, hi = 5, per_req = 10, ph = 0, since_rise = 0;
  bit gen_on = 0, stop_req = 0, stop_level = 0;

  pss_reset_seq #(
    .PRECHARGE_CYC(P), .PER_MIN(PMIN), .PER_MAX(PMAX),
    .STALL_CYC(STALL), .VALID_RUNS(RUNS), .DRAIN_CYC(DRAIN)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .gate_ok_i(gate_ok), .pwr_down_i(pwr_down),
    .mod_ready_i(mod_ready), .mute_i(mute), .pwm_i(pwm_i),
    .pwm_o(pwm_o), .bridge_en_o(bridge_en), .stage_rst_no(stage_rst_n)
  );

  initial forever #5 clk = ~clk;

  // PWM source: rise at phase 0, high for per/2 clocks
  initial forever begin
    @(negedge clk);
    if (since_rise < 1000000) since_rise++;
    if (gen_on) begin
      if (ph == 0) begin
        if (stop_req) begin
          gen_on = 0; stop_req = 0;
          if (stop_level) begin pwm_i = 1'b1; since_rise = 0; end
        end else begin
          per = per_req; hi = per / 2;
          pwm_i = 1'b1; since_rise = 0;
          ph = (per > 1) ? 1 : 0;
        end
      end else begin
        pwm_i = (ph < hi);
        ph = (ph + 1 == per) ? 0 : ph + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk); #1;
  endtask

  task automatic step0();
    @(negedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    gen_on = 1;
    step(3);
    // R1 reset state
    chk("R1 rst", stage_rst_n, 0); chk("R1 bridge", bridge_en, 0); chk("R1 pwm", pwm_o, 0);
    rst_ni = 1'b1;
    step(1);
    chk("R1 rst after release", stage_rst_n, 0); chk("R1 bridge after release", bridge_en, 0);
    mod_ready = 1'b1;
    step(30);
    chk("R2 no gate", bridge_en, 0);
    chk("R9 no fwd", pwm_o, 0);
    // R10 power-down request blocks start
    pwr_down = 1'b1; gate_ok = 1'b1;
    step(10);
    chk("R10 held off", bridge_en, 0);
    pwr_down = 1'b0;
    step(1);
    chk("R2 bridge up", bridge_en, 1);
    for (int k = 1; k < P; k++) begin
      step(1);
      if (stage_rst_n != 0 || pwm_o != 0) chk("R3 precharge hold", {stage_rst_n, pwm_o}, 0);
    end
    n_chk++;
    step(1);
    chk("R3 still low at P+1", stage_rst_n, 0);
    step(1);
    chk("R3 release at P+2", stage_rst_n, 1);

    for (int k = 0; k < 25; k++) begin
      step(1);
      chk("R9 forward", pwm_o, pwm_i);
    end

    // R4/R5 period sweep across both band edges
    for (int p = PMIN - 2; p <= PMAX + 2; p++) begin
      per_req = p;
      step(6 * p + 30);
      chk($sformatf("R5 period %0d", p), stage_rst_n, (p >= PMIN && p <= PMAX) ? 1 : 0);
      per_req = 10;
      if (p < PMIN || p > PMAX) begin
        step(30);
        chk("R4 run not yet complete", stage_rst_n, 0);
        step(70);
        chk("R4 run complete", stage_rst_n, 1);
      end else begin
        step(30);
      end
    end

    // R7 mute
    mute = 1'b1;
    step(1);
    chk("R7 mute low", stage_rst_n, 0);
    for (int k = 0; k < 15; k++) begin
      step(1);
      chk("R7 fwd during mute", pwm_o, pwm_i);
    end
    mute = 1'b0;
    step(1);
    chk("R7 unmute", stage_rst_n, 1);
    // R7 modulator not ready
    mod_ready = 1'b0;
    step(1);
    chk("R7 not ready", stage_rst_n, 0);
    step(20);
    chk("R7 stays low", stage_rst_n, 0);
    mod_ready = 1'b1;
    step(1);
    chk("R7 ready again", stage_rst_n, 1);

    // R6 stuck low, then stuck high
    for (int lvl = 0; lvl < 2; lvl++) begin
      step(40);
      chk("R6 pre", stage_rst_n, 1);
      stop_level = lvl[0]; stop_req = 1;
      while (gen_on) step0();
      while (since_rise < STALL + 2) step0();
      chk($sformatf("R6 stuck %0d before", lvl), stage_rst_n, 1);
      step0();
      chk($sformatf("R6 stuck %0d drop", lvl), stage_rst_n, 0);
      step(30);
      chk("R6 stays low", stage_rst_n, 0);
      ph = 0; gen_on = 1;
      step(100);
      chk("R6 recovered", stage_rst_n, 1);
    end

    // R8 power-down drain
    pwr_down = 1'b1;
    step(1);
    chk("R8 rst first", stage_rst_n, 0);
    chk("R8 bridge kept", bridge_en, 1);
    for (int k = 1; k < DRAIN; k++) begin
      step(1);
      chk("R8 drain fwd", pwm_o, pwm_i);
      chk("R8 drain bridge", bridge_en, 1);
    end
    step(1);
    chk("R8 bridge off", bridge_en, 0);
    for (int k = 0; k < 20; k++) begin
      step(1);
      chk("R9 gated", pwm_o, 0);
    end
    chk("R2 stays off", bridge_en, 0);

    // R10 restart repeats precharge
    pwr_down = 1'b0;
    step(1);
    chk("R10 bridge", bridge_en, 1);
    step(P);
    chk("R10 precharge low", stage_rst_n, 0);
    step(1);
    chk("R10 release", stage_rst_n, 1);

    // R8 gate supply loss
    step(20);
    gate_ok = 1'b0;
    step(1);
    chk("R8 gate loss rst", stage_rst_n, 0);
    step(DRAIN - 1);
    chk("R8 gate loss bridge held", bridge_en, 1);
    step(1);
    chk("R8 gate loss bridge off", bridge_en, 0);

    // R7 gate back but modulator not ready
    mod_ready = 1'b0; gate_ok = 1'b1;
    step(P + 10);
    chk("R7 waits modulator", stage_rst_n, 0);
    chk("R2 bridge back", bridge_en, 1);
    mod_ready = 1'b1;
    step(1);
    chk("R7 releases", stage_rst_n, 1);

    step(5);
    finish_run();
  end
endmodule